// File: doc/BRIEF.md
# Multi-channel match-compare timer

This block holds several independent up-counters, three by default. Each counter has a bank of match comparators. When the counter equals a comparator's programmed value, the comparator sets a sticky status bit. Each timer drives one interrupt line: the OR of its status bits that are enabled.

A single run-control word starts and stops all counters together, one bit per timer. Each timer selects one of two modes:
- Restart: the counter returns to zero after a comparator 0 match.
- Free-running: the counter wraps at its full width.

Software does not read the live counter. It writes a trigger to a snapshot register, and the sampled value appears at that address a fixed number of cycles later. All access goes through a plain synchronous register port: address, write strobe, write data and registered read data.

To get an event `d` counts after a timer starts, load `d-1` into a comparator. Deltas from 16 up to one below the counter's full range are the intended operating window.

Top module: `match_timer`

## Requirements
- R1: After a synchronous reset, every register reads zero except the match registers, which read all ones. Every interrupt output is low.
- R2: Bit t of the run-control word at address 0x00 enables timer t. An enabled counter reads 0 in the first cycle after the enabling write edge and advances by one each clock. While its bit is clear, the counter is held at zero, so re-enabling it restarts from zero.
- R3: Comparator c of an enabled timer sets status bit c at the clock edge that ends the cycle in which the counter equals match register c. With match value M, the status bit becomes set at the (M+1)-th edge after the enabling edge.
- R4: The status register is at offset 4. Writing 1 to bit c clears status bit c, and writing 0 leaves it unchanged. If a clear and a new match for the same bit land on the same edge, the bit ends up set.
- R5: The interrupt-enable register is at offset 5, bit c for comparator c. irq[t] is high exactly one cycle after some status bit of timer t is set while its enable bit is set. Status bits whose enable bit is clear never raise irq[t].
- R6: The mode register is at offset 6. Bit 0 = 1 selects restart mode: the counter becomes 0 on the edge after it equals comparator 0's value, and matches on the other comparators do not restart it. Bit 0 = 0 selects free-running mode: the counter wraps from all ones to zero.
- R7: The snapshot register is at offset 7. A write with bit 0 = 1 samples the counter value seen at that write edge. Reads issued on edges up to CAP_LAT edges after the trigger return the previous snapshot. Reads from CAP_LAT+1 edges after the trigger return the new one. A write with bit 0 = 0 changes nothing.
- R8: Timer t's registers sit at base 0x10*(t+1), with match register c at offset c. Written registers read back their value. Every unmapped address reads zero.
- R9: rdata is registered: it presents the register selected by addr one clock edge earlier.
- R10: Writes to one timer's registers and that timer's matches leave every other timer's counter, status and snapshot unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register word address |
| wr_en | input | 1 | Write strobe for the current cycle |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Registered read data |
| irq | output | NUM_TMR | One interrupt line per timer |

## Verification
The bench checks the exact cycle in which an interrupt rises after start. A design off by one cycle would flag it too early or too late.

It times a status clear to coincide with a new match in restart mode. A design that lets the clear win would lose that event.

Snapshot reads are checked on every cycle of the latency window. A design with a short pipe, or one that shows the live count, would return the new value early.

A narrower copy of the block runs past its counter width to check wrap-around. The bench also disables and re-enables a timer, which catches a counter that resumes instead of restarting. Captures at random intervals are compared against counts computed from the bench's own cycle counter.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int unsigned OFS_W = 4;

  typedef enum logic [OFS_W-1:0] {
    OFS_STAT = 4'h4,
    OFS_IEN  = 4'h5,
    OFS_MODE = 4'h6,
    OFS_SNAP = 4'h7
  } reg_ofs_e;

  typedef enum logic {
    MODE_FREE    = 1'b0,
    MODE_RESTART = 1'b1
  } run_mode_e;
endpackage

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart_mode,
  input  logic [CNT_W-1:0] match0,
  output logic [CNT_W-1:0] cnt_q
);
  logic at_limit;
  assign at_limit = restart_mode && (cnt_q == match0);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (at_limit) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/mt_cmp_bank.sv
module mt_cmp_bank #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned NUM_CMP = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           run,
  input  logic [CNT_W-1:0]               cnt,
  input  logic [NUM_CMP-1:0][CNT_W-1:0]  match,
  input  logic [NUM_CMP-1:0]             clr,
  input  logic [NUM_CMP-1:0]             ien,
  output logic [NUM_CMP-1:0]             stat_q,
  output logic                           irq_q
);
  logic [NUM_CMP-1:0] hit;

  for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
    assign hit[c] = run && (cnt == match[c]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr) | hit;
      irq_q  <= |(stat_q & ien);
    end
  end
endmodule

// File: rtl/mt_snapshot.sv
module mt_snapshot #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned LAT   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] snap_q
);
  localparam int unsigned LW = $clog2(LAT + 1);

  logic [CNT_W-1:0] pend_q;
  logic [LW-1:0]    left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      left_q <= '0;
      snap_q <= '0;
    end else begin
      if (left_q == LW'(1)) begin
        snap_q <= pend_q;
      end
      if (trig) begin
        pend_q <= cnt;
        left_q <= LW'(LAT);
      end else if (left_q != '0) begin
        left_q <= left_q - LW'(1);
      end
    end
  end
endmodule

// File: rtl/match_timer.sv
module match_timer #(
  parameter int unsigned NUM_TMR = 3,
  parameter int unsigned NUM_CMP = 3,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned CAP_LAT = 4,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [CNT_W-1:0]   wdata,
  output logic [CNT_W-1:0]   rdata,
  output logic [NUM_TMR-1:0] irq
);
  import mt_pkg::*;

  localparam int unsigned TSEL_W = ADDR_W - OFS_W;

  logic [TSEL_W-1:0] tsel;
  logic [OFS_W-1:0]  ofs;
  assign tsel = addr[ADDR_W-1:OFS_W];
  assign ofs  = addr[OFS_W-1:0];

  logic [NUM_TMR-1:0]                          en_q;
  logic [NUM_TMR-1:0]                          mode_q;
  logic [NUM_TMR-1:0][NUM_CMP-1:0]             ie_q;
  logic [NUM_TMR-1:0][NUM_CMP-1:0][CNT_W-1:0]  match_q;
  logic [NUM_TMR-1:0][NUM_CMP-1:0]             stat_q;
  logic [NUM_TMR-1:0][NUM_CMP-1:0]             clr;
  logic [NUM_TMR-1:0][CNT_W-1:0]               cnt_q;
  logic [NUM_TMR-1:0][CNT_W-1:0]               snap_q;
  logic [NUM_TMR-1:0]                          trig;
  logic [CNT_W-1:0]                            rd_nxt;

  // software-visible registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      mode_q  <= '0;
      ie_q    <= '0;
      match_q <= '1;
    end else if (wr_en) begin
      if (addr == '0) begin
        en_q <= wdata[NUM_TMR-1:0];
      end
      for (int t = 0; t < NUM_TMR; t++) begin
        if (tsel == TSEL_W'(t + 1)) begin
          for (int c = 0; c < NUM_CMP; c++) begin
            if (ofs == OFS_W'(c)) match_q[t][c] <= wdata;
          end
          if (ofs == OFS_IEN)  ie_q[t]   <= wdata[NUM_CMP-1:0];
          if (ofs == OFS_MODE) mode_q[t] <= wdata[0];
        end
      end
    end
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    logic sel;
    assign sel     = wr_en && (tsel == TSEL_W'(t + 1));
    assign clr[t]  = (sel && ofs == OFS_STAT) ? wdata[NUM_CMP-1:0] : '0;
    assign trig[t] = sel && (ofs == OFS_SNAP) && wdata[0];

    mt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk          (clk),
      .rst          (rst),
      .run          (en_q[t]),
      .restart_mode (mode_q[t] == MODE_RESTART),
      .match0       (match_q[t][0]),
      .cnt_q        (cnt_q[t])
    );

    mt_cmp_bank #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_cmp (
      .clk    (clk),
      .rst    (rst),
      .run    (en_q[t]),
      .cnt    (cnt_q[t]),
      .match  (match_q[t]),
      .clr    (clr[t]),
      .ien    (ie_q[t]),
      .stat_q (stat_q[t]),
      .irq_q  (irq[t])
    );

    mt_snapshot #(.CNT_W(CNT_W), .LAT(CAP_LAT)) u_snap (
      .clk    (clk),
      .rst    (rst),
      .trig   (trig[t]),
      .cnt    (cnt_q[t]),
      .snap_q (snap_q[t])
    );
  end

  // read multiplexer
  always_comb begin
    rd_nxt = '0;
    if (addr == '0) begin
      rd_nxt[NUM_TMR-1:0] = en_q;
    end
    for (int t = 0; t < NUM_TMR; t++) begin
      if (tsel == TSEL_W'(t + 1)) begin
        for (int c = 0; c < NUM_CMP; c++) begin
          if (ofs == OFS_W'(c)) rd_nxt = match_q[t][c];
        end
        if (ofs == OFS_STAT) rd_nxt[NUM_CMP-1:0] = stat_q[t];
        if (ofs == OFS_IEN)  rd_nxt[NUM_CMP-1:0] = ie_q[t];
        if (ofs == OFS_MODE) rd_nxt[0]           = mode_q[t];
        if (ofs == OFS_SNAP) rd_nxt              = snap_q[t];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nxt;
  end
endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
  parameter int unsigned NUM_TMR = 3,
  parameter int unsigned NUM_CMP = 3,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input logic                              clk,
  input logic                              rst,
  input logic [ADDR_W-1:0]                 addr,
  input logic                              wr_en,
  input logic [NUM_CMP-1:0]                wd_lo,
  input logic [NUM_TMR-1:0]                irq,
  input logic [NUM_TMR-1:0]                en_q,
  input logic [NUM_TMR-1:0]                mode_q,
  input logic [NUM_TMR-1:0][NUM_CMP-1:0]   ie_q,
  input logic [NUM_TMR-1:0][NUM_CMP-1:0]   stat_q,
  input logic [NUM_TMR-1:0][CNT_W-1:0]     cnt_q
);
  for (genvar t = 0; t < NUM_TMR; t++) begin : g_t
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'((t + 1) * 16 + 4);

    p_hold_zero_r2: assert property (@(posedge clk) disable iff (rst)
      !$past(en_q[t]) |-> cnt_q[t] == '0);

    p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
      ($past(en_q[t]) && cnt_q[t] != '0) |-> (cnt_q[t] - $past(cnt_q[t])) == CNT_W'(1));

    p_free_no_restart_r6: assert property (@(posedge clk) disable iff (rst)
      ($past(en_q[t]) && !$past(mode_q[t]) && $past(cnt_q[t]) != '1) |-> cnt_q[t] != '0);

    p_irq_needs_enable_r5: assert property (@(posedge clk) disable iff (rst)
      irq[t] |-> $past(ie_q[t] != '0));

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_c
      p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(stat_q[t][c]) && !$past(wr_en && addr == STAT_A && wd_lo[c])) |-> stat_q[t][c]);
    end
  end
endmodule

bind match_timer mt_checker #(
  .NUM_TMR(NUM_TMR), .NUM_CMP(NUM_CMP), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wd_lo(wdata[NUM_CMP-1:0]),
  .irq(irq), .en_q(en_q), .mode_q(mode_q), .ie_q(ie_q), .stat_q(stat_q), .cnt_q(cnt_q)
);

// File: tb/match_timer_tb_top.sv
module match_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;
  logic [7:0]  rdata_s;
  logic [2:0]  irq_s;

  always #2 clk = ~clk;

  match_timer dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  match_timer #(.CNT_W(8)) dut_s (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata[7:0]),
    .rdata(rdata_s), .irq(irq_s)
  );

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int unsigned wlast;
  int unsigned e1, e2, c;
  logic [31:0] v, prev;
  logic [7:0]  vs;

  localparam int M1 = 20;
  localparam int M2 = 20;

  function automatic logic [7:0] ra(int t, int o);
    return 8'((t + 1) * 16 + o);
  endfunction

  function automatic logic [31:0] exp_free(int unsigned cap, int unsigned en);
    return 32'(cap - en - 1);
  endfunction

  function automatic logic [31:0] exp_rst(int unsigned cap, int unsigned en, int m);
    return 32'((cap - en - 1) % (m + 1));
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    wlast = cyc;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d, output logic [7:0] ds);
    addr = a; wr_en = 1'b0;
    @(negedge clk);
    d = rdata; ds = rdata_s;
  endtask

  task automatic snap(int t, output int unsigned ce, output logic [31:0] d, output logic [7:0] ds);
    logic [31:0] x; logic [7:0] xs;
    wr(ra(t, 7), 32'h1);
    ce = wlast;
    repeat (4) rd(ra(t, 7), x, xs);
    rd(ra(t, 7), d, ds);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h00, v, vs);       check("R1 run-control", v, 32'h0);
    rd(ra(0, 0), v, vs);    check("R1 match reset", v, 32'hFFFF_FFFF);
    rd(ra(1, 7), v, vs);    check("R1 snapshot reset", v, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);

    // configuration
    wr(ra(1, 0), M1); wr(ra(1, 1), 1000); wr(ra(1, 2), 2000);
    wr(ra(1, 5), 32'h1); wr(ra(1, 6), 32'h0);
    wr(ra(2, 0), M2); wr(ra(2, 1), 10); wr(ra(2, 2), 32'hFFFF_FFF0);
    wr(ra(2, 6), 32'h1);

    // R8 map and readback, R9 registered read
    rd(ra(2, 1), v, vs);    check("R8 match readback", v, 32'd10);
    rd(ra(2, 6), v, vs);    check("R8 mode readback", v, 32'h1);
    rd(ra(1, 5), v, vs);    check("R8 enable readback", v, 32'h1);
    rd(ra(0, 3), v, vs);    check("R8 unmapped offset", v, 32'h0);
    rd(8'h08, v, vs);       check("R8 unmapped low", v, 32'h0);
    rd(8'hF0, v, vs);       check("R8 unmapped high", v, 32'h0);
    addr = ra(2, 0);
    @(posedge clk); #1;
    addr = ra(2, 1);
    check("R9 read lags address", rdata, M2);

    // R2 start timers 1 and 2
    @(negedge clk);
    wr(8'h00, 32'h6);
    e1 = wlast; e2 = wlast;

    // R3 / R5 exact interrupt cycle
    while (cyc < e1 + M1 + 1) @(negedge clk);
    check("R3 irq not yet", 32'(irq[1]), 32'h0);
    @(negedge clk);
    check("R3 irq rises", 32'(irq[1]), 32'h1);
    check("R5 masked timer quiet", 32'(irq[2]), 32'h0);
    check("R10 idle timer quiet", 32'(irq[0]), 32'h0);
    rd(ra(1, 4), v, vs);    check("R3 status bits", v, 32'h1);

    // R4 write-one-to-clear
    wr(ra(1, 4), 32'h6);
    rd(ra(1, 4), v, vs);    check("R4 zero bits keep status", v, 32'h1);
    wr(ra(1, 4), 32'h1);
    rd(ra(1, 4), v, vs);    check("R4 clear", v, 32'h0);
    check("R5 irq drops after clear", 32'(irq[1]), 32'h0);

    // R4 match beats clear on the same edge (timer 2 hits at e2 + 21k)
    begin
      int unsigned w;
      w = e2 + (M2 + 1) * ((cyc + 1 - e2) / (M2 + 1) + 1);
      while (cyc < w - 1) @(negedge clk);
    end
    wr(ra(2, 4), 32'h1);
    rd(ra(2, 4), v, vs);    check("R4 match wins over clear", v & 32'h1, 32'h1);
    wr(ra(2, 4), 32'h1);
    rd(ra(2, 4), v, vs);    check("R4 clear off a match", v & 32'h1, 32'h0);

    // R5 unmask a pending bit (comparator 1 of timer 2)
    wr(ra(2, 5), 32'h2);
    check("R5 irq one cycle after enable", 32'(irq[2]), 32'h0);
    @(negedge clk);
    check("R5 irq follows enabled status", 32'(irq[2]), 32'h1);
    wr(ra(2, 5), 32'h0);

    // R7 snapshot latency
    wr(ra(1, 7), 32'h1);
    c = wlast;
    for (int i = 0; i < 4; i++) begin
      rd(ra(1, 7), v, vs);
      check("R7 old value inside window", v, 32'h0);
    end
    rd(ra(1, 7), v, vs);
    check("R7 snapshot value", v, exp_free(c, e1));
    check("R7 narrow snapshot", 32'(vs), 32'(exp_free(c, e1) & 32'hFF));
    prev = v;
    wr(ra(1, 7), 32'h2);
    repeat (6) @(negedge clk);
    rd(ra(1, 7), v, vs);    check("R7 bit0 clear ignored", v, prev);

    // R6 restart mode wraps at comparator 0 only
    snap(2, c, v, vs);      check("R6 restart count", v, exp_rst(c, e2, M2));

    // R10 untouched timer
    snap(0, c, v, vs);      check("R10 idle snapshot", v, 32'h0);
    rd(ra(0, 4), v, vs);    check("R10 idle status", v, 32'h0);

    // R2 disable clears, re-enable restarts
    wr(8'h00, 32'h4);
    repeat (3) @(negedge clk);
    snap(1, c, v, vs);      check("R2 disabled counter", v, 32'h0);
    snap(2, c, v, vs);      check("R10 neighbour keeps running", v, exp_rst(c, e2, M2));
    wr(8'h00, 32'h6);
    e1 = wlast;
    repeat (7) @(negedge clk);
    snap(1, c, v, vs);      check("R2 restart from zero", v, exp_free(c, e1));

    // R6 free-running wrap (narrow instance)
    repeat (300) @(negedge clk);
    snap(1, c, v, vs);
    check("R6 free count", v, exp_free(c, e1));
    check("R6 narrow wrap", 32'(vs), 32'(exp_free(c, e1) & 32'hFF));

    // random capture intervals
    for (int i = 0; i < 20; i++) begin
      int t;
      repeat ($urandom_range(0, 40)) @(negedge clk);
      t = ($urandom_range(0, 1) == 0) ? 1 : 2;
      snap(t, c, v, vs);
      if (t == 1) begin
        check("R7 random free snapshot", v, exp_free(c, e1));
        check("R6 random narrow wrap", 32'(vs), 32'(exp_free(c, e1) & 32'hFF));
      end else begin
        check("R6 random restart snapshot", v, exp_rst(c, e2, M2));
        check("R6 random narrow restart", 32'(vs), exp_rst(c, e2, M2));
      end
    end

    finish_run();
  end
endmodule